// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Scheduler

This block computes a crossbar configuration for an N-by-N input-queued switch that keeps one virtual output queue per input and output pair. A caller presents a request matrix in which bit `i*N + j` is set when input `i` holds cells for output `j`, and pulses `start_i`. The scheduler then builds a matching over a series of iterations, one per clock cycle. In every iteration, free outputs each grant one requesting free input, and free inputs each accept one of the grants they received.

Both choices are round-robin. A grant arbiter per output and an accept arbiter per input each search from a stored pointer. After a pair is accepted in the first iteration of a schedule, the pointers move one position past the port just served, so that port drops to the lowest priority. Under light load the outcomes look scattered. Under a full load the pointers fall out of step and the schedule settles into a fixed rotation.

The run ends after a configured number of iterations, limited to N, or earlier when an iteration adds no pair. At that point `done_o` rises and the per-input and per-output match vectors are valid. They stay valid until the next accepted start.

Top module: `islip_sched`

## Requirements
- R1: After reset, `done_o` is low, no input or output is marked matched, and every grant and accept pointer points at port 0. For example, an all-ones matrix scheduled first with at least N iterations yields input i matched to output i.
- R2: In each iteration, every unmatched output that has requests from unmatched inputs grants exactly one of them: the first requesting input found by searching upward from its grant pointer and wrapping from N-1 to 0.
- R3: In each iteration, every unmatched input that received grants accepts exactly one of them: the first granting output found by searching upward from its accept pointer, with wrap-around. Each accepted pair is added to the matching.
- R4: Pointers change only on accepts made in the first iteration. The output's grant pointer becomes the accepted input plus one modulo N, and the input's accept pointer becomes the accepted output plus one modulo N. Grants that are not accepted leave the pointer unchanged.
- R5: Ports matched in an earlier iteration take no part in later ones. When `done_o` is high, the result is a consistent matching: if input i reports output j, then output j reports input i, and the two match counts are equal.
- R6: A pair is only matched if its bit was set in the request matrix captured at start.
- R7: One iteration takes one clock cycle. `done_o` rises after the iteration count is reached, or after the first iteration that adds no pair, whichever comes first. An all-zero matrix therefore finishes after one cycle.
- R8: Once `done_o` is high, it and all match outputs hold until a new `start_i`. A `start_i` that arrives while a schedule is running is ignored.
- R9: An iteration parameter larger than N is treated as N.
- R10: When the effective iteration count equals N, the finished matching is maximal: no unmatched input has a request to an unmatched output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a schedule using `req_i` (taken only when no schedule is running) |
| req_i | input | N*N | Request matrix; bit i*N+j set when input i has cells for output j |
| done_o | output | 1 | Schedule finished and outputs valid |
| in_hit_o | output | N | Bit i set when input i is matched |
| in_sel_o | output | N*log2(N) | Field i: output matched to input i |
| out_hit_o | output | N | Bit j set when output j is matched |
| out_sel_o | output | N*log2(N) | Field j: input matched to output j |

## Verification
Pointer movement and the addition of new pairs happen together in the first-iteration cycle. A second start can also land in a cycle where a schedule is still running. The bench runs a full matrix right after reset, so the first iteration both updates pointers and fills one pair. It then repeats the same matrix, which makes the stale and fresh pointers produce different diagonals. During a run of a full matrix it pulses a conflicting start carrying an empty matrix. The result must still equal the reference model's answer for the first matrix, and the completion cycle must stay the same.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N = 4,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] ptr,
    output logic         hit,
    output logic [W-1:0] idx
);
    // programmable priority encoder: first set bit at or above ptr, wrapping
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (!hit && req[(int'(ptr) + k) % N]) begin
                hit = 1'b1;
                idx = W'((int'(ptr) + k) % N);
            end
        end
    end
endmodule

// File: rtl/islip_sched.sv
module islip_sched
    import sched_pkg::*;
#(
    parameter int N     = 4,
    parameter int ITERS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start_i,
    input  logic [N*N-1:0]                     req_i,
    output logic                               done_o,
    output logic [N-1:0]                       in_hit_o,
    output logic [N*((N>1)?$clog2(N):1)-1:0]   in_sel_o,
    output logic [N-1:0]                       out_hit_o,
    output logic [N*((N>1)?$clog2(N):1)-1:0]   out_sel_o
);
    localparam int W        = (N > 1) ? $clog2(N) : 1;
    localparam int ITER_EFF = (ITERS < 1) ? 1 : ((ITERS > N) ? N : ITERS);
    localparam int CW       = $clog2(ITER_EFF + 1);

    typedef struct packed {
        phase_e              ph;
        logic [CW-1:0]       iter;
        logic [N*N-1:0]      req;
        logic [N-1:0]        in_hit;
        logic [N-1:0][W-1:0] in_sel;
        logic [N-1:0]        out_hit;
        logic [N-1:0][W-1:0] out_sel;
        logic [N-1:0][W-1:0] gptr;
        logic [N-1:0][W-1:0] aptr;
    } st_t;

    st_t st_q, st_d;

    logic [N-1:0][N-1:0] g_req;
    logic [N-1:0]        g_any;
    logic [N-1:0][W-1:0] g_idx;
    logic [N-1:0][N-1:0] a_req;
    logic [N-1:0]        a_any;
    logic [N-1:0][W-1:0] a_idx;
    logic                busy;

    function automatic logic [W-1:0] step(input logic [W-1:0] x);
        return (int'(x) == N - 1) ? '0 : W'(int'(x) + 1);
    endfunction

    // grant side: output j sees requests from free inputs
    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                g_req[j][i] = st_q.req[i*N + j] & ~st_q.in_hit[i] & ~st_q.out_hit[j];
            end
        end
    end

    for (genvar gj = 0; gj < N; gj++) begin : g_grant
        rr_pick #(.N(N), .W(W)) u_pick (
            .req (g_req[gj]),
            .ptr (st_q.gptr[gj]),
            .hit (g_any[gj]),
            .idx (g_idx[gj])
        );
    end

    // accept side: input i sees grants addressed to it
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                a_req[i][j] = g_any[j] && (g_idx[j] == W'(i));
            end
        end
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_accept
        rr_pick #(.N(N), .W(W)) u_pick (
            .req (a_req[gi]),
            .ptr (st_q.aptr[gi]),
            .hit (a_any[gi]),
            .idx (a_idx[gi])
        );
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_RUN: begin
                for (int i = 0; i < N; i++) begin
                    if (a_any[i]) begin
                        st_d.in_hit[i]           = 1'b1;
                        st_d.in_sel[i]           = a_idx[i];
                        st_d.out_hit[a_idx[i]]   = 1'b1;
                        st_d.out_sel[a_idx[i]]   = W'(i);
                        if (st_q.iter == '0) begin
                            st_d.gptr[a_idx[i]] = step(W'(i));
                            st_d.aptr[i]        = step(a_idx[i]);
                        end
                    end
                end
                st_d.iter = st_q.iter + 1'b1;
                if (!(|a_any) || st_q.iter == CW'(ITER_EFF - 1)) begin
                    st_d.ph = PH_DONE;
                end
            end
            default: begin
                if (start_i) begin
                    st_d.ph      = PH_RUN;
                    st_d.iter    = '0;
                    st_d.req     = req_i;
                    st_d.in_hit  = '0;
                    st_d.in_sel  = '0;
                    st_d.out_hit = '0;
                    st_d.out_sel = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.ph == PH_RUN);
    assign done_o    = (st_q.ph == PH_DONE);
    assign in_hit_o  = st_q.in_hit;
    assign in_sel_o  = st_q.in_sel;
    assign out_hit_o = st_q.out_hit;
    assign out_sel_o = st_q.out_sel;
endmodule

// File: rtl/islip_sched_chk.sv
module islip_sched_chk #(
    parameter int N    = 4,
    parameter int W    = 2,
    parameter bit FULL = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [N*N-1:0] req_i,
    input logic           busy_i,
    input logic           done_o,
    input logic [N-1:0]   in_hit_o,
    input logic [N*W-1:0] in_sel_o,
    input logic [N-1:0]   out_hit_o,
    input logic [N*W-1:0] out_sel_o
);
    logic [N*N-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cap_q <= '0;
        else if (start_i && !busy_i) cap_q <= req_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_in
        logic [W-1:0] sel;
        assign sel = in_sel_o[i*W +: W];

        // R5
        pair_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && in_hit_o[i]) |->
                (out_hit_o[sel] && out_sel_o[int'(sel)*W +: W] == W'(i)));

        // R6
        req_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && in_hit_o[i]) |-> cap_q[i*N + int'(sel)]);

        if (FULL) begin : g_full
            for (genvar j = 0; j < N; j++) begin : g_out
                // R10
                maximal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    done_o |-> !(cap_q[i*N + j] && !in_hit_o[i] && !out_hit_o[j]));
            end
        end
    end

    // R5
    count_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones(in_hit_o) == $countones(out_hit_o)));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(in_hit_o) && $stable(in_sel_o)
                                  && $stable(out_hit_o) && $stable(out_sel_o)));

    // R7
    run_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (busy_i || done_o));

    // R7
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_i));
endmodule

bind islip_sched islip_sched_chk #(.N(N), .W(W), .FULL(ITER_EFF == N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .req_i     (req_i),
    .busy_i    (busy),
    .done_o    (done_o),
    .in_hit_o  (in_hit_o),
    .in_sel_o  (in_sel_o),
    .out_hit_o (out_hit_o),
    .out_sel_o (out_sel_o)
);

// File: tb/islip_sched_bench.sv
module islip_sched_bench;
    localparam int N = 4;
    localparam int W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic           start_a = 1'b0, start_b = 1'b0;
    logic [N*N-1:0] req_a = '0, req_b = '0;
    logic           done_a, done_b;
    logic [N-1:0]   ih_a, oh_a, ih_b, oh_b;
    logic [N*W-1:0] is_a, os_a, is_b, os_b;

    // ITERS above N exercises the cap (R9)
    islip_sched #(.N(N), .ITERS(6)) u_islip_sched (
        .clk(clk), .rst_n(rst_n), .start_i(start_a), .req_i(req_a),
        .done_o(done_a), .in_hit_o(ih_a), .in_sel_o(is_a),
        .out_hit_o(oh_a), .out_sel_o(os_a)
    );

    islip_sched #(.N(N), .ITERS(1)) u_islip_sched_single (
        .clk(clk), .rst_n(rst_n), .start_i(start_b), .req_i(req_b),
        .done_o(done_b), .in_hit_o(ih_b), .in_sel_o(is_b),
        .out_hit_o(oh_b), .out_sel_o(os_b)
    );

    int checks = 0;
    int failures = 0;
    int gp [2][N];
    int ap [2][N];
    int eim[2][N];
    int eom[2][N];
    int ecyc[2];
    int wd = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // reference model from the requirements
    task automatic model(input int u, input logic [N*N-1:0] rq, input int iters);
        int gnt[N];
        int added;
        bit stop;
        for (int i = 0; i < N; i++) begin eim[u][i] = -1; eom[u][i] = -1; end
        ecyc[u] = 0;
        stop = 1'b0;
        for (int it = 0; it < iters; it++) begin
            if (!stop) begin
                ecyc[u]++;
                for (int j = 0; j < N; j++) begin
                    bit f;
                    gnt[j] = -1;
                    f = 1'b0;
                    if (eom[u][j] < 0) begin
                        for (int k = 0; k < N; k++) begin
                            int i;
                            i = (gp[u][j] + k) % N;
                            if (!f && eim[u][i] < 0 && rq[i*N + j]) begin
                                gnt[j] = i; f = 1'b1;
                            end
                        end
                    end
                end
                added = 0;
                for (int i = 0; i < N; i++) begin
                    bit f;
                    f = 1'b0;
                    if (eim[u][i] < 0) begin
                        for (int k = 0; k < N; k++) begin
                            int j;
                            j = (ap[u][i] + k) % N;
                            if (!f && gnt[j] == i) begin
                                f = 1'b1;
                                eim[u][i] = j;
                                eom[u][j] = i;
                                added++;
                                if (it == 0) begin
                                    gp[u][j] = (i + 1) % N;
                                    ap[u][i] = (j + 1) % N;
                                end
                            end
                        end
                    end
                end
                if (added == 0) stop = 1'b1;
            end
        end
    endtask

    function automatic int act_sel(input logic [N-1:0] hit, input logic [N*W-1:0] sel, input int p);
        return hit[p] ? int'(sel[p*W +: W]) : -1;
    endfunction

    task automatic run(input logic [N*N-1:0] rq, input bit clash, input logic [N*N-1:0] rq2,
                       input string tag);
        int ca, cb;
        model(0, rq, N);
        model(1, rq, 1);
        @(negedge clk);
        req_a = rq; req_b = rq; start_a = 1'b1; start_b = 1'b1;
        @(negedge clk);
        start_a = 1'b0; start_b = 1'b0;
        ca = 0; cb = 0;
        for (int n = 1; n <= 10; n++) begin
            if (clash && n == 1) begin
                start_a = 1'b1; req_a = rq2;
            end
            @(negedge clk);
            start_a = 1'b0;
            if (done_a && ca == 0) ca = n;
            if (done_b && cb == 0) cb = n;
        end
        chk(ca == ecyc[0], tag, "R7 R9 iterations (multi)", ca, ecyc[0]);
        chk(cb == ecyc[1], tag, "R7 iterations (single)", cb, ecyc[1]);
        chk(done_a && done_b, tag, "R8 done held", int'(done_a) + int'(done_b), 2);
        for (int p = 0; p < N; p++) begin
            chk(act_sel(ih_a, is_a, p) == eim[0][p], tag, "R2/R3/R4/R5 input match (multi)",
                act_sel(ih_a, is_a, p), eim[0][p]);
            chk(act_sel(oh_a, os_a, p) == eom[0][p], tag, "R2/R3/R5/R6 output match (multi)",
                act_sel(oh_a, os_a, p), eom[0][p]);
            chk(act_sel(ih_b, is_b, p) == eim[1][p], tag, "R3/R4 input match (single)",
                act_sel(ih_b, is_b, p), eim[1][p]);
            chk(act_sel(oh_b, os_b, p) == eom[1][p], tag, "R2/R4 output match (single)",
                act_sel(oh_b, os_b, p), eom[1][p]);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int u = 0; u < 2; u++)
            for (int p = 0; p < N; p++) begin gp[u][p] = 0; ap[u][p] = 0; end
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!done_a && !done_b, "reset", "R1 done low", int'(done_a), 0);
        chk(ih_a == '0 && oh_a == '0, "reset", "R1 no matches", int'(ih_a), 0);

        // R1 pointers at zero: full matrix yields the diagonal
        run(16'hFFFF, 1'b0, '0, "full_first");
        for (int p = 0; p < N; p++)
            chk(act_sel(ih_a, is_a, p) == p, "full_first", "R1 diagonal", act_sel(ih_a, is_a, p), p);
        // R4 moved pointers shift the second full schedule
        run(16'hFFFF, 1'b0, '0, "full_second");
        // R7 empty matrix finishes after one cycle
        run(16'h0000, 1'b0, '0, "empty");
        // R8 start during a run is ignored
        run(16'hFFFF, 1'b1, 16'h0000, "clash");
        // R2 one output wanted by all inputs
        run(16'h1111, 1'b0, '0, "hot_output");
        // R3 one input wants every output
        run(16'h00F0, 1'b0, '0, "hot_input");
        // permutation
        run(16'h8421, 1'b0, '0, "perm");
        run(16'h0001, 1'b0, '0, "single_req");

        for (int r = 0; r < 60; r++) begin
            logic [N*N-1:0] rq;
            rq = N*N'($urandom);
            if (r % 3 == 0) rq = rq & N*N'($urandom);
            run(rq, (r % 7 == 3), N*N'($urandom), "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule